// File: doc/BRIEF.md
# Masked Pattern-Match Input Interrupt

This block watches groups of input pins and compares each group against a pattern that software writes. A per-pin mask takes pins out of the comparison. A group is *matched* when every unmasked pin equals its pattern bit. The block raises an event only when a group leaves the matched state. Moving from one mismatching pattern to another gives no event. To get a new event, the group must first become matched again. That happens when the pins return to the pattern or when software rewrites the pattern or the mask.

Each group has three registers: a compare pattern, a mask, and a control register. The control register holds an interrupt enable bit and the interrupt factor flag. Any event sets the flag, whatever the enable bit says. The interrupt output is the flag gated by the enable bit. Pins pass through a two-flop synchronizer before the comparison. The number of groups and their width are parameters. The default is two groups of four pins.

Top module: `pinMatchIrq`

## Requirements
- R1: After reset, every compare register reads 0, every mask register reads all ones (all pins masked), every control register reads 0, and no event, flag or interrupt output is active.
- R2: For group g, the compare pattern is at address 4g+0, the mask at 4g+1 and the control register at 4g+2. Each reads back what was last written to it. In the control register, bit 0 is the enable and bit 1 is the flag.
- R3: When a group goes from matched to unmatched because of its pins, its event output pulses high for exactly one cycle. The pulse appears three clock edges after the pin change (two synchronizer stages plus the event register).
- R4: A change from one unmatched pin pattern to another unmatched pattern produces no event.
- R5: A pin whose mask bit is 1 has no effect. Changing it neither produces an event nor breaks a match.
- R6: After an event, a group gives a further event only after it has become matched again by its pins.
- R7: Writing the compare or mask register never produces an event, even when the new setting leaves the group unmatched. If the group then becomes matched, a later break produces an event.
- R8: An event sets the group's flag whether or not the enable is set. The interrupt output equals flag AND enable.
- R9: Writing the control register with bit 1 set clears the flag. The flag otherwise holds. If a clear and an event arrive on the same edge, the flag ends up set.
- R10: The groups are independent. Pins and register writes of one group do not change another group's registers, events or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | NUM_GROUPS*PIN_W | Asynchronous pins; group g uses bits [g*PIN_W +: PIN_W] |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address for both read and write |
| regWrData | input | PIN_W | Register write data |
| regRdData | output | PIN_W | Combinational read data for regAddr |
| eventOut | output | NUM_GROUPS | One-cycle match-break pulse per group |
| flagOut | output | NUM_GROUPS | Interrupt factor flag per group |
| irqOut | output | NUM_GROUPS | Flag gated by enable, per group |

## Verification
The hardest case to reach is a flag clear that lands on the same edge as a new event. The pin change must be placed exactly three edges before the clear write takes effect. The bench drives the mismatch, counts two edges, and then issues the control write so that it is sampled on the edge where the event register loads.

A similar timing problem arises when a configuration write leaves the group unmatched. The bench watches the event output over a window of cycles to confirm it stays quiet, and then re-arms the group through its pins.

// File: rtl/pmi_pkg.sv
package pmi_pkg;
  localparam int REGS_PER_GROUP = 4;
  localparam int OFF_CMP = 0;
  localparam int OFF_MASK = 1;
  localparam int OFF_CTL = 2;
  localparam int CTL_EN_BIT = 0;
  localparam int CTL_FLAG_BIT = 1;

  typedef struct packed {
    logic wrCmp;
    logic wrMask;
    logic wrCtl;
  } pmiStrobe_t;
endpackage

// File: rtl/pmi_ctrl.sv
module pmi_ctrl
  import pmi_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int PIN_W = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PIN_W-1:0]  rdCmp  [NUM_GROUPS],
  input  logic [PIN_W-1:0]  rdMask [NUM_GROUPS],
  input  logic              rdEn   [NUM_GROUPS],
  input  logic              rdFlag [NUM_GROUPS],
  output pmiStrobe_t        stb    [NUM_GROUPS],
  output logic [PIN_W-1:0]  regRdData
);
  localparam int GRP_W = ADDR_W - 2;

  logic [GRP_W-1:0] grpSel;
  logic [1:0]       offSel;

  assign grpSel = regAddr[ADDR_W-1:2];
  assign offSel = regAddr[1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gDecode
    logic hit;
    assign hit = regWrEn && (grpSel == GRP_W'(g));
    assign stb[g].wrCmp  = hit && (offSel == 2'(OFF_CMP));
    assign stb[g].wrMask = hit && (offSel == 2'(OFF_MASK));
    assign stb[g].wrCtl  = hit && (offSel == 2'(OFF_CTL));
  end

  always_comb begin
    regRdData = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grpSel == GRP_W'(g)) begin
        case (offSel)
          2'(OFF_CMP):  regRdData = rdCmp[g];
          2'(OFF_MASK): regRdData = rdMask[g];
          2'(OFF_CTL): begin
            regRdData[CTL_EN_BIT]   = rdEn[g];
            regRdData[CTL_FLAG_BIT] = rdFlag[g];
          end
          default: regRdData = '0;
        endcase
      end
    end
  end

  logic [3*NUM_GROUPS-1:0] allStb;
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gFlat
    assign allStb[3*g +: 3] = {stb[g].wrCmp, stb[g].wrMask, stb[g].wrCtl};
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(allStb)); // R10
endmodule

// File: rtl/pmi_datapath.sv
module pmi_datapath
  import pmi_pkg::*;
#(
  parameter int PIN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIN_W-1:0] pinsAsync,
  input  pmiStrobe_t       stb,
  input  logic [PIN_W-1:0] wrData,
  output logic [PIN_W-1:0] cmpQ,
  output logic [PIN_W-1:0] maskQ,
  output logic             enQ,
  output logic             flagQ,
  output logic             eventQ,
  output logic             irqQ
);
  logic [PIN_W-1:0] syncA, syncB;
  logic prevMatch, cfgQuiet;
  logic matchNow, breakNow, clrReq;

  assign matchNow = ~|((syncB ^ cmpQ) & ~maskQ);
  assign breakNow = prevMatch && !matchNow && !cfgQuiet;
  assign clrReq   = stb.wrCtl && wrData[CTL_FLAG_BIT];
  assign irqQ     = flagQ && enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= '0;
      syncB     <= '0;
      cmpQ      <= '0;
      maskQ     <= '1;
      enQ       <= 1'b0;
      prevMatch <= 1'b1;
      cfgQuiet  <= 1'b0;
      eventQ    <= 1'b0;
      flagQ     <= 1'b0;
    end else begin
      syncA     <= pinsAsync;
      syncB     <= syncA;
      if (stb.wrCmp)  cmpQ  <= wrData;
      if (stb.wrMask) maskQ <= wrData;
      if (stb.wrCtl)  enQ   <= wrData[CTL_EN_BIT];
      cfgQuiet  <= stb.wrCmp || stb.wrMask;
      prevMatch <= matchNow;
      eventQ    <= breakNow;
      flagQ     <= breakNow || (flagQ && !clrReq);
    end
  end

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    eventQ |=> !eventQ); // R3
  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    eventQ |-> flagQ); // R8
  AST_CFG_NO_EVT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCmp || stb.wrMask) |=> ##1 !eventQ); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (breakNow && clrReq) |=> flagQ); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !clrReq) |=> flagQ); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> enQ); // R8
endmodule

// File: rtl/pinMatchIrq.sv
module pinMatchIrq
  import pmi_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int PIN_W = 4,
  localparam int ADDR_W = $clog2(NUM_GROUPS * REGS_PER_GROUP)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_GROUPS*PIN_W-1:0] pinIn,
  input  logic                        regWrEn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [PIN_W-1:0]            regWrData,
  output logic [PIN_W-1:0]            regRdData,
  output logic [NUM_GROUPS-1:0]       eventOut,
  output logic [NUM_GROUPS-1:0]       flagOut,
  output logic [NUM_GROUPS-1:0]       irqOut
);
  pmiStrobe_t       stb    [NUM_GROUPS];
  logic [PIN_W-1:0] rdCmp  [NUM_GROUPS];
  logic [PIN_W-1:0] rdMask [NUM_GROUPS];
  logic             rdEn   [NUM_GROUPS];
  logic             rdFlag [NUM_GROUPS];

  pmi_ctrl #(.NUM_GROUPS(NUM_GROUPS), .PIN_W(PIN_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .rdCmp(rdCmp), .rdMask(rdMask), .rdEn(rdEn), .rdFlag(rdFlag),
    .stb(stb), .regRdData(regRdData)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    pmi_datapath #(.PIN_W(PIN_W)) uDp (
      .clk(clk), .rstN(rstN),
      .pinsAsync(pinIn[g*PIN_W +: PIN_W]),
      .stb(stb[g]), .wrData(regWrData),
      .cmpQ(rdCmp[g]), .maskQ(rdMask[g]), .enQ(rdEn[g]), .flagQ(rdFlag[g]),
      .eventQ(eventOut[g]), .irqQ(irqOut[g])
    );
    assign flagOut[g] = rdFlag[g];
  end
endmodule

// File: tb/tb_pinMatchIrq.sv
module tb_pinMatchIrq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pinIn = '0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [3:0] regWrData = '0;
  logic [3:0] regRdData;
  logic [1:0] eventOut, flagOut, irqOut;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pinMatchIrq dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .eventOut(eventOut), .flagOut(flagOut), .irqOut(irqOut)
  );

  // group 0 pins, expected event; compare 0101, mask 1000
  localparam logic [4:0] VEC [8] = '{
    5'b0101_0,  // R3 stays matched
    5'b1101_0,  // R5 masked pin moves
    5'b1100_1,  // R3 break on bit 0
    5'b1110_0,  // R4 mismatch to mismatch
    5'b0101_0,  // R6 back to match
    5'b0001_1,  // R6 re-armed break
    5'b0101_0,
    5'b1111_1   // R3 break on bit 1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input logic [2:0] a, input logic [3:0] exp);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  task automatic setPins(input logic [7:0] p);
    @(negedge clk);
    pinIn = p;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int quiet;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdCheck("R1 cmp0", 3'd0, 4'h0);
    rdCheck("R1 mask0", 3'd1, 4'hF);
    rdCheck("R1 ctl0", 3'd2, 4'h0);
    rdCheck("R1 mask1", 3'd5, 4'hF);
    check("R1 outs", {eventOut, flagOut, irqOut}, 0);

    // R2 setup and readback
    wrReg(3'd0, 4'b0101);
    wrReg(3'd1, 4'b1000);
    rdCheck("R2 cmp0", 3'd0, 4'b0101);
    rdCheck("R2 mask0", 3'd1, 4'b1000);
    setPins(8'h05);
    check("R7 no event after cfg", flagOut[0], 0);

    foreach (VEC[i]) begin
      setPins({pinIn[7:4], VEC[i][4:1]});
      check($sformatf("R3 vec%0d event", i), eventOut[0], VEC[i][0]);
      @(negedge clk);
      check($sformatf("R3 vec%0d pulse end", i), eventOut[0], 0);
    end

    // R8 flag without enable, then gating
    check("R8 flag set, en off", flagOut[0], 1);
    check("R8 irq off", irqOut[0], 0);
    wrReg(3'd2, 4'b0001);
    check("R8 irq on", irqOut[0], 1);
    rdCheck("R2 ctl0", 3'd2, 4'b0011);
    wrReg(3'd2, 4'b0011);
    check("R9 flag cleared", flagOut[0], 0);
    check("R9 irq cleared", irqOut[0], 0);

    // R7 cfg write into mismatch gives no event
    setPins(8'h05);
    wrReg(3'd0, 4'b0110);
    quiet = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (eventOut[0]) quiet++;
    end
    check("R7 quiet window", quiet, 0);
    check("R7 flag stays", flagOut[0], 0);
    setPins(8'h06);
    check("R7 rematch no event", eventOut[0], 0);
    setPins(8'h07);
    check("R7 break after rematch", eventOut[0], 1);
    check("R8 irq with en", irqOut[0], 1);

    // R9 clear and event on same edge
    setPins(8'h06);
    wrReg(3'd2, 4'b0010);
    check("R9 cleared", flagOut[0], 0);
    @(negedge clk);
    pinIn = 8'h07;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd2; regWrData = 4'b0010;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    check("R9 set wins event", eventOut[0], 1);
    check("R9 set wins flag", flagOut[0], 1);

    // R10 group independence
    wrReg(3'd4, 4'b0000);
    wrReg(3'd5, 4'b0000);
    rdCheck("R10 cmp0 kept", 3'd0, 4'b0110);
    setPins(8'h17);
    check("R10 grp1 event", eventOut, 2'b10);
    check("R10 grp0 flag kept", flagOut, 2'b11);
    wrReg(3'd6, 4'b0010);
    check("R10 clr grp1 only", flagOut, 2'b01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule